// File: doc/BRIEF.md
# Packet-Granular Round-Robin Reader

The block takes packets from eight per-port receive queues and delivers them, one packet after another, onto a single 128-bit upstream bus. Each queue shows its head word (data, start flag, end flag, valid) and a flag that says whether a complete packet is waiting. The block reads a queue by pulsing that port's read strobe. Every word it delivers upstream carries the 3-bit number of the port it came from. The upstream side can stall the bus with a ready signal.

Service rotates among the ports that have a packet waiting, one packet per turn, so every port gets an even share. The block picks a new port only at a packet boundary. Once a port is granted, the block keeps it from the start word until the end word has been accepted upstream. The host can name a port with the skip controls. At the next boundary that port is served first, provided it has a packet waiting. The rotation pointer is not moved by such a skip grant.

The control is a three-state machine. ARB picks a port. MOVE pops words from the granted port into the output register. DRAIN waits for the end word to leave. The transitions are:
- ARB to MOVE when a skip hit or a rotation pick exists in that cycle. ARB stays in ARB when no port has a packet.
- MOVE to DRAIN when the word just popped carries the end flag. MOVE stays in MOVE otherwise.
- DRAIN to ARB when the upstream bus accepts the end word.

Top module: `pkt_rr_reader`

## Requirements
- R1: At most one port's read strobe is high in any cycle, and a strobe is raised only while that port's head word is valid.
- R2: Each upstream word carries the 128-bit head word of the serving port unchanged, together with that port's 3-bit number and its start and end flags.
- R3: The rotation pointer resets to port 0. Without a skip, the next port served is the first port with a packet waiting, searching upward from the pointer and wrapping from 7 to 0. After a rotation grant of port g, the pointer becomes g+1, modulo 8.
- R4: Words of different packets never interleave. Once a start word from port p is delivered, every following word comes from port p up to and including the end word. A new packet begins only after that end word is accepted.
- R5: When a boundary is reached while skip_req is high and the port numbered by the 3-bit skip_port has a packet waiting, that port is served next.
- R6: A skip naming a port with no packet waiting has no effect: the rotation order of R3 is kept.
- R7: A skip grant leaves the rotation pointer where it was, so rotation resumes from the pre-skip position.
- R8: Ports without a waiting packet are passed over in the single arbitration cycle. With ready held high, the next start word is accepted exactly 3 cycles after the previous end word is accepted.
- R9: While up_valid is high and up_ready is low, up_valid, up_data, up_port, up_sop and up_eop hold their values.
- R10: After reset, up_valid is low and no read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_avail | input | 8 | A complete packet is waiting in the port queue |
| port_valid | input | 8 | The head word of the port queue is valid |
| port_sop | input | 8 | The head word starts a packet |
| port_eop | input | 8 | The head word ends a packet |
| port_data | input | 1024 | Head words, port i at bits [128*i +: 128] |
| port_rd | output | 8 | Pop strobe for each port queue |
| skip_req | input | 1 | Host asks for the named port out of turn |
| skip_port | input | 3 | Port number named by the skip request |
| up_ready | input | 1 | Upstream accepts the current word |
| up_valid | output | 1 | Upstream word is valid |
| up_data | output | 128 | Upstream data word |
| up_port | output | 3 | Number of the port the word came from |
| up_sop | output | 1 | Upstream word starts a packet |
| up_eop | output | 1 | Upstream word ends a packet |

## Verification
The assertions assume that each queue holds its head word steady until it is popped, and that port_avail is raised only when the head word is a start word of a fully stored packet. They also assume that skip_port does not change while skip_req is high during arbitration. The bench keeps to these rules. It writes each scenario's packets into its queue models all at once while the block is idle, derives port_avail from a non-empty queue, sets the skip controls before loading, and changes them only after the scenario has drained. Backpressure comes from a pseudo-random ready pattern that touches only up_ready.

// File: rtl/pkt_rr_pkg.sv
package pkt_rr_pkg;

    typedef enum logic [1:0] {
        ST_ARB   = 2'd0,
        ST_MOVE  = 2'd1,
        ST_DRAIN = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] pick
);

    int idx;

    // Search upward from base, wrapping around; the first requester wins.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(base) + i) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
    import pkt_rr_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  port_avail,
    input  logic [N-1:0]  port_valid,
    input  logic [N-1:0]  port_eop,
    input  logic          skip_req,
    input  logic [IW-1:0] skip_port,
    input  logic          take_ok,
    input  logic          eop_done,
    output logic [IW-1:0] grant,
    output logic          pop,
    output logic [N-1:0]  port_rd
);

    rd_state_e     state_q, state_d;
    logic [IW-1:0] grant_q, grant_d;
    logic [IW-1:0] ptr_q, ptr_d;
    logic          rr_found;
    logic [IW-1:0] rr_idx;
    logic          skip_hit;
    logic          head_valid;
    logic          head_eop;

    rr_pick #(.N(N), .IW(IW)) u_pick (
        .req   (port_avail),
        .base  (ptr_q),
        .found (rr_found),
        .pick  (rr_idx)
    );

    assign skip_hit   = skip_req && port_avail[skip_port];
    assign head_valid = port_valid[grant_q];
    assign head_eop   = port_eop[grant_q];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARB;
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next state, grant and pointer
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_ARB: begin
                if (skip_hit) begin
                    grant_d = skip_port;
                    state_d = ST_MOVE;
                end else if (rr_found) begin
                    grant_d = rr_idx;
                    ptr_d   = (int'(rr_idx) == N - 1) ? '0 : rr_idx + 1'b1;
                    state_d = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (pop && head_eop) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (eop_done) begin
                    state_d = ST_ARB;
                end
            end
            default: state_d = ST_ARB;
        endcase
    end

    // Outputs
    always_comb begin
        pop   = (state_q == ST_MOVE) && head_valid && take_ok;
        grant = grant_q;
    end

    for (genvar g = 0; g < N; g++) begin : g_rd
        assign port_rd[g] = pop && (int'(grant_q) == g);
    end

    // R1: a single queue is read at a time
    p_rd_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_rd));

    // R5: a skip hit at a boundary grants the named port
    p_skip_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && skip_req && port_avail[skip_port])
        |=> (state_q == ST_MOVE && grant_q == $past(skip_port)));

    // R7: the rotation pointer is left alone by a skip grant
    p_skip_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && skip_req && port_avail[skip_port])
        |=> (ptr_q == $past(ptr_q)));

    // R8: arbitration completes in one cycle whenever any packet waits
    p_pass_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARB && (|port_avail)) |=> (state_q == ST_MOVE));

endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int DW = 128,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_load,
    input  logic [DW-1:0] in_data,
    input  logic [IW-1:0] in_port,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic          up_ready,
    output logic          take_ok,
    output logic          up_valid,
    output logic [DW-1:0] up_data,
    output logic [IW-1:0] up_port,
    output logic          up_sop,
    output logic          up_eop
);

    assign take_ok = !up_valid || up_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_valid <= 1'b0;
            up_data  <= '0;
            up_port  <= '0;
            up_sop   <= 1'b0;
            up_eop   <= 1'b0;
        end else if (take_ok) begin
            up_valid <= in_load;
            if (in_load) begin
                up_data <= in_data;
                up_port <= in_port;
                up_sop  <= in_sop;
                up_eop  <= in_eop;
            end
        end
    end

    // R9: a stalled word is held
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready) |=> (up_valid && $stable(up_data) &&
        $stable(up_port) && $stable(up_sop) && $stable(up_eop)));

endmodule

// File: rtl/pkt_rr_reader.sv
module pkt_rr_reader #(
    parameter int NPORTS = 8,
    parameter int DW     = 128,
    localparam int IW    = $clog2(NPORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    port_avail,
    input  logic [NPORTS-1:0]    port_valid,
    input  logic [NPORTS-1:0]    port_sop,
    input  logic [NPORTS-1:0]    port_eop,
    input  logic [NPORTS*DW-1:0] port_data,
    output logic [NPORTS-1:0]    port_rd,
    input  logic                 skip_req,
    input  logic [IW-1:0]        skip_port,
    input  logic                 up_ready,
    output logic                 up_valid,
    output logic [DW-1:0]        up_data,
    output logic [IW-1:0]        up_port,
    output logic                 up_sop,
    output logic                 up_eop
);

    logic [IW-1:0] grant;
    logic          pop;
    logic          take_ok;
    logic          eop_done;
    logic [DW-1:0] masked [NPORTS];
    logic [DW-1:0] sel_data;

    assign eop_done = up_valid && up_ready && up_eop;

    grant_fsm #(.N(NPORTS), .IW(IW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_avail (port_avail),
        .port_valid (port_valid),
        .port_eop   (port_eop),
        .skip_req   (skip_req),
        .skip_port  (skip_port),
        .take_ok    (take_ok),
        .eop_done   (eop_done),
        .grant      (grant),
        .pop        (pop),
        .port_rd    (port_rd)
    );

    // Data mux as an AND-OR tree over the granted port
    for (genvar g = 0; g < NPORTS; g++) begin : g_mux
        assign masked[g] = (int'(grant) == g) ? port_data[g*DW +: DW] : '0;
    end

    always_comb begin
        sel_data = '0;
        for (int i = 0; i < NPORTS; i++) begin
            sel_data = sel_data | masked[i];
        end
    end

    out_stage #(.DW(DW), .IW(IW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_load  (pop),
        .in_data  (sel_data),
        .in_port  (grant),
        .in_sop   (port_sop[grant]),
        .in_eop   (port_eop[grant]),
        .up_ready (up_ready),
        .take_ok  (take_ok),
        .up_valid (up_valid),
        .up_data  (up_data),
        .up_port  (up_port),
        .up_sop   (up_sop),
        .up_eop   (up_eop)
    );

    // R4: inside a packet the serving port does not change
    p_same_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !up_eop) |=> (up_port == $past(up_port)));

    // R4: a word that follows an accepted mid-packet word is not a start word
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !up_eop) |=> !(up_valid && up_sop));

endmodule

// File: tb/pkt_rr_reader_bench.sv
module pkt_rr_reader_bench;

    localparam int N  = 8;
    localparam int DW = 128;
    localparam int QD = 128;

    typedef struct packed {
        logic [2:0]    port;
        logic          sop;
        logic          eop;
        logic [DW-1:0] data;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    port_avail, port_valid, port_sop, port_eop, port_rd;
    logic [N*DW-1:0] port_data;
    logic            skip_req = 1'b0;
    logic [2:0]      skip_port = 3'd0;
    logic            up_ready = 1'b1;
    logic            up_valid, up_sop, up_eop;
    logic [DW-1:0]   up_data;
    logic [2:0]      up_port;

    int checks = 0;
    int failures = 0;
    exp_t exq[$];
    string cur_tag = "R3";
    bit rnd_ready = 0;
    bit gap_en = 0;
    bit have_last = 0;
    int last_eop_cyc = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    int ptr_m = 0;
    int scen = 0;

    logic [DW+1:0] pmem [N][QD];
    int wr_i [N];
    int rd_i [N];

    always #10 clk = ~clk;

    pkt_rr_reader u_pkt_rr_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_avail (port_avail),
        .port_valid (port_valid),
        .port_sop   (port_sop),
        .port_eop   (port_eop),
        .port_data  (port_data),
        .port_rd    (port_rd),
        .skip_req   (skip_req),
        .skip_port  (skip_port),
        .up_ready   (up_ready),
        .up_valid   (up_valid),
        .up_data    (up_data),
        .up_port    (up_port),
        .up_sop     (up_sop),
        .up_eop     (up_eop)
    );

    // Queue models: head word of each port
    for (genvar p = 0; p < N; p++) begin : g_q
        logic [DW+1:0] head;
        assign head                  = pmem[p][rd_i[p] % QD];
        assign port_valid[p]         = (wr_i[p] != rd_i[p]);
        assign port_avail[p]         = port_valid[p];
        assign port_sop[p]           = head[DW+1];
        assign port_eop[p]           = head[DW];
        assign port_data[p*DW +: DW] = head[DW-1:0];
    end

    initial begin
        for (int p = 0; p < N; p++) begin
            wr_i[p] = 0;
            rd_i[p] = 0;
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (port_rd[p]) rd_i[p] <= rd_i[p] + 1;
        end
    end

    // Ready pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        up_ready <= rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    function automatic logic [DW-1:0] make_word(int p, int gid, int w);
        return {32'(p), 32'(gid), 32'(w), 32'hA5A50000 ^ 32'(gid * 7 + w)};
    endfunction

    // Monitor / scoreboard
    logic          stall_q = 1'b0;
    logic [DW-1:0] h_data;
    logic [2:0]    h_port;
    logic          h_sop, h_eop;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            checks = checks + 1;
            if (!$onehot0(port_rd) || ((port_rd & ~port_valid) != 0)) begin
                failures = failures + 1;
                $display("FAIL R1 read strobes: got rd=%b valid=%b expected one-hot among valid",
                         port_rd, port_valid);
            end
            if (stall_q) begin
                checks = checks + 1;
                if (!up_valid || up_data != h_data || up_port != h_port ||
                    up_sop != h_sop || up_eop != h_eop) begin
                    failures = failures + 1;
                    $display("FAIL R9 hold: got v=%0b port=%0d data=%h expected v=1 port=%0d data=%h",
                             up_valid, up_port, up_data, h_port, h_data);
                end
            end
            stall_q = up_valid && !up_ready;
            h_data = up_data; h_port = up_port; h_sop = up_sop; h_eop = up_eop;
            if (up_valid && up_ready) begin
                checks = checks + 1;
                if (exq.size() == 0) begin
                    failures = failures + 1;
                    $display("FAIL %s/R4 unexpected word: got port=%0d data=%h expected none",
                             cur_tag, up_port, up_data);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    if (e.port != up_port || e.sop != up_sop || e.eop != up_eop ||
                        e.data != up_data) begin
                        failures = failures + 1;
                        $display("FAIL %s/R2/R4 word: got port=%0d sop=%0b eop=%0b data=%h expected port=%0d sop=%0b eop=%0b data=%h",
                                 cur_tag, up_port, up_sop, up_eop, up_data,
                                 e.port, e.sop, e.eop, e.data);
                    end
                end
                if (up_sop && gap_en && have_last) begin
                    checks = checks + 1;
                    if (cyc - last_eop_cyc != 3) begin
                        failures = failures + 1;
                        $display("FAIL R8 gap: got %0d cycles expected 3", cyc - last_eop_cyc);
                    end
                end
                if (up_eop) begin
                    have_last = 1;
                    last_eop_cyc = cyc;
                end
            end
        end
    end

    // Driver: load queues and push the expected order from the rotation model
    task automatic run_scenario(input int cnt[N], input bit skip_on, input int sk,
                                input string tag);
        int lens [N][8];
        int left [N];
        int next_k [N];
        int total;
        int g;
        scen = scen + 1;
        cur_tag = tag;
        skip_req = skip_on;
        skip_port = 3'(sk);
        total = 0;
        for (int p = 0; p < N; p++) begin
            left[p] = cnt[p];
            next_k[p] = 0;
            total = total + cnt[p];
            for (int k = 0; k < cnt[p]; k++) begin
                lens[p][k] = 1 + ((p * 3 + k * 5 + scen) % 6);
                for (int w = 0; w < lens[p][k]; w++) begin
                    pmem[p][wr_i[p] % QD] = {(w == 0), (w == lens[p][k] - 1),
                        make_word(p, scen * 256 + p * 16 + k, w)};
                    wr_i[p] = wr_i[p] + 1;
                end
            end
        end
        while (total > 0) begin
            g = -1;
            if (skip_on && left[sk] > 0) begin
                g = sk;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (g < 0 && left[(ptr_m + i) % N] > 0) g = (ptr_m + i) % N;
                end
                ptr_m = (g + 1) % N;
            end
            for (int w = 0; w < lens[g][next_k[g]]; w++) begin
                exp_t e;
                e.port = 3'(g);
                e.sop  = (w == 0);
                e.eop  = (w == lens[g][next_k[g]] - 1);
                e.data = make_word(g, scen * 256 + g * 16 + next_k[g], w);
                exq.push_back(e);
            end
            next_k[g] = next_k[g] + 1;
            left[g] = left[g] - 1;
            total = total - 1;
        end
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while ((exq.size() != 0 || up_valid) && t < 5000) begin
            @(negedge clk);
            t = t + 1;
        end
        checks = checks + 1;
        if (t >= 5000) begin
            failures = failures + 1;
            $display("FAIL %s drain: got %0d words left expected 0", cur_tag, exq.size());
        end
        repeat (4) @(negedge clk);
        skip_req = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        failures = failures + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        checks = checks + 1;
        if (up_valid !== 1'b0) begin
            failures = failures + 1;
            $display("FAIL R10 up_valid: got %b expected 0", up_valid);
        end
        checks = checks + 1;
        if (port_rd !== '0) begin
            failures = failures + 1;
            $display("FAIL R10 port_rd: got %b expected 0", port_rd);
        end
        // R3: one packet per port, full rotation from pointer 0
        run_scenario('{1, 1, 1, 1, 1, 1, 1, 1}, 0, 0, "R3");
        wait_idle();
        // R8: only ports 0 and 7 waiting, ready high, fixed boundary gap
        have_last = 0;
        gap_en = 1;
        run_scenario('{2, 0, 0, 0, 0, 0, 0, 2}, 0, 0, "R8");
        wait_idle();
        gap_en = 0;
        // R9: random backpressure with short and single-word packets
        rnd_ready = 1;
        run_scenario('{0, 0, 3, 3, 0, 3, 0, 0}, 0, 0, "R9");
        wait_idle();
        rnd_ready = 0;
        // R5 and R7: skip to port 5, rotation resumes from the old pointer
        run_scenario('{0, 2, 0, 0, 0, 1, 2, 0}, 1, 5, "R5/R7");
        wait_idle();
        // R6: skip names empty port 3
        run_scenario('{1, 0, 0, 0, 2, 0, 0, 0}, 1, 3, "R6");
        wait_idle();
        // R5 under backpressure, skip port 0 with two packets
        rnd_ready = 1;
        run_scenario('{2, 1, 0, 1, 0, 0, 1, 0}, 1, 0, "R5");
        wait_idle();
        rnd_ready = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule